// File: doc/BRIEF.md
# Upward-Only Counter Word Bank

This block holds a small bank of two-byte counters. A counter can be raised and never lowered, which makes it suitable for tamper-resistant tallies such as distance totals, metered energy or remaining credit. Each counter sits at a fixed pair of byte addresses at the bottom of a larger byte-addressed array. An upstream serial front end decodes each frame and passes it to the bank as a one-cycle transaction. The transaction carries a kind flag (counter update or plain write), the starting byte address, the two data bytes merged into one 16-bit value with the first byte as the high byte, and the number of serial clock pulses the frame took.

The bank applies an update only when all of these hold: the frame is a counter update, the write-enable latch is set, the address is even and inside the bank, and the frame was exactly 40 pulses long (8 opcode, 16 address and 16 data bits). For such a frame it compares the new value with the stored word. The word is replaced only when the new value is strictly larger. The comparison result is kept in a flag. A one-cycle completion pulse tells the front end to clear its write-enable latch. A combinational byte read port lets the front end serve reads of the region.

Top module: `mono_counter_bank`

## Requirements
- R1: After reset every word reads 0x0000, `cmp_low` is 0 and `upd_done` is 0.
- R2: A qualified update whose value is strictly greater than the stored word replaces that word. The new value is visible on the read port from the cycle after the transaction.
- R3: An update to an odd byte address (bit 0 = 1) is cancelled. No word changes and `upd_done` stays 0.
- R4: A transaction with `upd_is_inc` = 0 (a plain byte or page write) never changes any word and never raises `upd_done`.
- R5: An update whose `upd_clks` is not exactly 40 is cancelled. No word changes and `upd_done` stays 0.
- R6: For a qualified update, `cmp_low` becomes 1 when the new value is lower than or equal to the stored word and 0 when it is greater. A cancelled or ignored transaction leaves `cmp_low` unchanged.
- R7: An update presented while `wel` = 0 is ignored. No word changes and `upd_done` stays 0.
- R8: An update to a byte address at or above 2*WORDS (0x020 by default) is ignored by the bank, and reads at such addresses return 0x00.
- R9: Byte reads return the high byte of word k at address 2k and the low byte at address 2k+1.
- R10: `upd_done` pulses for exactly one cycle, the cycle after every qualified update, whether the compare accepted or rejected the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid | input | 1 | One-cycle strobe: a decoded frame is presented |
| upd_is_inc | input | 1 | 1 = counter update frame, 0 = plain write frame |
| upd_addr | input | ADDR_W | Starting byte address of the frame |
| upd_data | input | 16 | New value, first received byte in bits 15:8 |
| upd_clks | input | CNT_W | Serial clock pulses counted over the whole frame |
| wel | input | 1 | Write-enable latch state from the front end |
| rd_addr | input | ADDR_W | Byte address to read |
| rd_byte | output | 8 | Byte at `rd_addr` (0 outside the bank) |
| cmp_low | output | 1 | Last compare result: 1 = new value was not greater |
| upd_done | output | 1 | One-cycle pulse after a qualified update |

## Verification
A corrupted word shows at once on the combinational read port, so every scenario ends by reading all 32 bytes and comparing them with a model. A wrongly stored or lowered word is therefore caught in the same scenario that caused it. A qualification fault, such as a missing parity, length, kind or enable check, shows the cycle after the strobe as a stray `upd_done` pulse or a changed word. A faulty compare shows in that same cycle as a wrong `cmp_low`, and equal values are exercised on purpose to separate strict from non-strict comparison.

// File: rtl/mono_counter_bank.sv
module mono_counter_bank #(
  parameter int WORDS      = 16,
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 8,
  parameter int FRAME_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic              upd_is_inc,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [15:0]       upd_data,
  input  logic [CNT_W-1:0]  upd_clks,
  input  logic              wel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic              cmp_low,
  output logic              upd_done
);
  localparam int IDX_W = $clog2(WORDS);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(2 * WORDS);

  logic [15:0] word_q [WORDS];

  wire [IDX_W-1:0] upd_idx = upd_addr[IDX_W:1];
  wire             qualified = upd_valid && upd_is_inc && wel && !upd_addr[0]
                               && (upd_addr < LIMIT)
                               && (upd_clks == CNT_W'(FRAME_CLKS));
  wire             greater = upd_data > word_q[upd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) word_q[i] <= '0;
      cmp_low  <= 1'b0;
      upd_done <= 1'b0;
    end else begin
      upd_done <= qualified;
      if (qualified) begin
        cmp_low <= !greater;
        if (greater) word_q[upd_idx] <= upd_data;
      end
    end
  end

  wire [15:0] rd_word = word_q[rd_addr[IDX_W:1]];
  assign rd_byte = (rd_addr >= LIMIT) ? 8'h00 :
                   rd_addr[0]         ? rd_word[7:0] : rd_word[15:8];

  for (genvar g = 0; g < WORDS; g++) begin : g_chk
    assert_never_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
      word_q[g] >= $past(word_q[g]));
    assert_change_means_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_q[g] != $past(word_q[g])) |-> (upd_done && !cmp_low));
  end

  assert_done_needs_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(upd_valid && wel));
  assert_done_needs_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(upd_is_inc));
  assert_done_even_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> !$past(upd_addr[0]));
  assert_done_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> ($past(upd_clks) == CNT_W'(FRAME_CLKS)));
  assert_done_in_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> ($past(upd_addr) < LIMIT));
  assert_flag_only_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_done |-> $stable(cmp_low));
endmodule

// File: tb/test_mono_counter_bank.sv
module test_mono_counter_bank;
  logic       clk = 0, rst_n = 0;
  logic       upd_valid = 0, upd_is_inc = 0, wel = 0;
  logic [9:0] upd_addr = '0, rd_addr = '0;
  logic [15:0] upd_data = '0;
  logic [7:0] upd_clks = '0;
  logic [7:0] rd_byte;
  logic       cmp_low, upd_done;

  int tests = 0, fails = 0;
  logic [15:0] model [16];

  always #10 clk = ~clk;

  mono_counter_bank i_mono_counter_bank (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_is_inc(upd_is_inc),
    .upd_addr(upd_addr), .upd_data(upd_data), .upd_clks(upd_clks), .wel(wel),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .cmp_low(cmp_low), .upd_done(upd_done));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    for (int a = 0; a < 32; a++) begin
      rd_addr = 10'(a);
      #1;
      chk(tag, {24'(a), rd_byte},
          {24'(a), (a % 2 == 0) ? model[a/2][15:8] : model[a/2][7:0]});
    end
  endtask

  task automatic send(input logic kind, input logic [9:0] addr, input logic [15:0] data,
                      input logic [7:0] clks, input logic en,
                      input logic exp_done, input logic exp_flag, input string tag);
    @(negedge clk);
    upd_valid = 1; upd_is_inc = kind; upd_addr = addr; upd_data = data;
    upd_clks = clks; wel = en;
    @(negedge clk);
    upd_valid = 0;
    chk({tag, " done"}, upd_done, exp_done);
    chk({tag, " flag"}, cmp_low, exp_flag);
    @(negedge clk);
    chk({tag, " done pulse ends R10"}, upd_done, 0);
  endtask

  task automatic t_reset;
    chk("R1 flag", cmp_low, 0);
    chk("R1 done", upd_done, 0);
    chk_all("R1 words zero");
  endtask

  task automatic t_increase;
    send(1, 10'h006, 16'h1234, 40, 1, 1, 0, "R2 raise");
    model[3] = 16'h1234;
    rd_addr = 10'h006; #1 chk("R9 high byte", rd_byte, 8'h12);
    rd_addr = 10'h007; #1 chk("R9 low byte", rd_byte, 8'h34);
    chk_all("R2 after raise");
  endtask

  task automatic t_equal_lower;
    send(1, 10'h006, 16'h1234, 40, 1, 1, 1, "R6 equal rejected R10");
    send(1, 10'h006, 16'h1000, 40, 1, 1, 1, "R6 lower rejected");
    send(1, 10'h006, 16'h1235, 40, 1, 1, 0, "R6 higher accepted");
    model[3] = 16'h1235;
    send(1, 10'h006, 16'h0001, 40, 1, 1, 1, "R6 set flag");
    chk_all("R6 words");
  endtask

  task automatic t_odd;
    send(1, 10'h007, 16'h2000, 40, 1, 0, 1, "R3 odd addr");
    chk_all("R3 words");
  endtask

  task automatic t_plain;
    send(0, 10'h006, 16'hFFFF, 40, 1, 0, 1, "R4 plain write");
    send(0, 10'h000, 16'hFFFF, 40, 1, 0, 1, "R4 plain write w0");
    chk_all("R4 words");
  endtask

  task automatic t_len;
    send(1, 10'h004, 16'h0100, 39, 1, 0, 1, "R5 len 39");
    send(1, 10'h004, 16'h0100, 41, 1, 0, 1, "R5 len 41");
    send(1, 10'h004, 16'h0100, 48, 1, 0, 1, "R5 len 48");
    chk_all("R5 words");
  endtask

  task automatic t_wel;
    send(1, 10'h004, 16'h0100, 40, 0, 0, 1, "R7 no enable");
    chk_all("R7 words");
  endtask

  task automatic t_outside;
    send(1, 10'h020, 16'h5555, 40, 1, 0, 1, "R8 above bank");
    send(1, 10'h3FE, 16'h5555, 40, 1, 0, 1, "R8 top addr");
    rd_addr = 10'h020; #1 chk("R8 read outside", rd_byte, 0);
    rd_addr = 10'h021; #1 chk("R8 read outside odd", rd_byte, 0);
    chk_all("R8 words");
  endtask

  task automatic t_edges;
    send(1, 10'h000, 16'hFFFF, 40, 1, 1, 0, "R2 word0 max");
    model[0] = 16'hFFFF;
    send(1, 10'h01E, 16'h0001, 40, 1, 1, 0, "R2 word15");
    model[15] = 16'h0001;
    send(1, 10'h000, 16'hFFFF, 40, 1, 1, 1, "R6 max equal");
    rd_addr = 10'h01E; #1 chk("R9 last high", rd_byte, 8'h00);
    rd_addr = 10'h01F; #1 chk("R9 last low", rd_byte, 8'h01);
    chk_all("R9 final words");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    #1;
    t_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    t_reset();
    t_increase();
    t_equal_lower();
    t_odd();
    t_plain();
    t_len();
    t_wel();
    t_outside();
    t_edges();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule